// File: doc/BRIEF.md
# Quasi-bidirectional GPIO port register

This block is one port of a small controller's special-function-register bus. Each pad is open-drain. An output latch holds the bit pattern the software wrote. A latch bit of 0 pulls its pad low. A latch bit of 1 releases the pad, and the pad then works as an input. There is no direction register. Software writes whole bytes, or sets and clears single bits. The single-bit operation is done inside the block as a read-modify-write on the latch.

Software can read the port in two ways. A plain read of the primary address returns the pad levels, after a two-flop synchroniser. This lets software sense a shared open-drain line that another device is pulling low. A read flagged as read-modify-write returns the latch contents instead, and so does any read of a second alias address. A bit that was just set, but whose heavily loaded pad has not yet risen, therefore cannot be lost when a later bit operation targets a neighbouring bit.

Top module: `gpio_port_sfr`

## Requirements
- R1: After reset the latch holds all ones and `pad_oe` is all zero, so no pad is pulled low.
- R2: A byte write (`bus_wr`=1) to the pin address (default 0x80) or to the latch alias (default 0xC0) loads `bus_wdata` into the latch on the next clock edge. From then on `pad_oe` equals the bitwise inverse of the latch (1 = pull the pad low).
- R3: A bit operation (`bus_bit_op`=1, `bus_wr`=0) at either address writes `bus_bit_val` (1 = set, 0 = clear) into latch bit `bus_bit_idx` on the next edge. All other latch bits keep their value.
- R4: A read (`bus_rd`=1, `bus_rmw`=0) at the pin address returns the pad level as it was two clock edges earlier.
- R5: A read with `bus_rmw`=1 at the pin address returns the latch contents in the same cycle.
- R6: A read at the latch alias returns the latch contents, whatever the value of `bus_rmw`.
- R7: After a bit set on bit 0 while its pad is still held low, a bit set on bit 1 leaves latch bit 0 at 1.
- R8: Writes and bit operations at any other address leave the latch unchanged, and reads there return zero.
- R9: `bus_rdata` is zero whenever `bus_rd` is 0.
- R10: When `bus_wr` and `bus_bit_op` are both high in the same cycle, the byte write takes effect and the bit operation is dropped.
- R11: A pad whose latch bit is 1 is released. A plain pin read then returns the level an external device drives on it, while the latch alias still returns 1 for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bit_op | input | 1 | Single-bit set/clear strobe |
| bus_bit_idx | input | 3 | Bit selected by the bit operation |
| bus_bit_val | input | 1 | Value written by the bit operation |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as the first half of a read-modify-write |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pad pull-low enable |

## Verification
The hardest case to reach is a pad that lags its latch. The latch says 1, but the pad still reads 0, and a bit operation on another bit arrives in that window. In a real system this comes from a slow rising edge. The bench reproduces it by holding `pad_in` low by force after the latch is set. It then checks that a plain read shows the low pad, that a read-modify-write read shows the latch, and that a second bit set keeps the first bit. The two-edge lag of the pin view is reached by changing `pad_in` and reading after one edge, then again after the second edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // which value drives the read data bus
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_PIN   = 2'd1,
      SRC_LATCH = 2'd2
   } rd_src_e;

   typedef struct packed {
      logic pin_view;
      logic latch_view;
   } addr_hit_t;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W              = 8,
   parameter logic [ADDR_W-1:0] PIN_ADDR   = 8'h80,
   parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'hC0,
   parameter bit RMW_READS_LATCH     = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              rmw,
   output addr_hit_t         hit,
   output rd_src_e           rd_src
);

   logic rmw_to_latch;

   assign hit.pin_view   = (addr == PIN_ADDR);
   assign hit.latch_view = (addr == LATCH_ADDR);

   generate
      if (RMW_READS_LATCH) begin : g_rmw_latch
         assign rmw_to_latch = rmw;
      end else begin : g_rmw_pin
         assign rmw_to_latch = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_src = SRC_NONE;
      if (rd) begin
         if (hit.latch_view) begin
            rd_src = SRC_LATCH;
         end else if (hit.pin_view) begin
            rd_src = rmw_to_latch ? SRC_LATCH : SRC_PIN;
         end
      end
   end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int WIDTH                 = 8,
   parameter int STAGES                = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_latch.sv
module gpio_port_latch #(
   parameter int WIDTH                 = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '1,
   localparam int IDX_W                = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wdata,
   input  logic             bit_en,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] q_next;

   // bit update reads the latch itself, never the pads
   always_comb begin
      q_next = q;
      if (wr_en) begin
         q_next = wdata;
      end else if (bit_en) begin
         q_next[bit_idx] = bit_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= q_next;
   end

endmodule

// File: rtl/gpio_port_sfr.sv
module gpio_port_sfr
   import gpio_port_pkg::*;
#(
   parameter int WIDTH                 = 8,
   parameter int ADDR_W                = 8,
   parameter logic [ADDR_W-1:0] PIN_ADDR   = 8'h80,
   parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'hC0,
   parameter int SYNC_STAGES           = 2,
   parameter bit RMW_READS_LATCH       = 1'b1,
   localparam int IDX_W                = $clog2(WIDTH),
   localparam logic [WIDTH-1:0] RELEASED = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic              bus_bit_op,
   input  logic [IDX_W-1:0]  bus_bit_idx,
   input  logic              bus_bit_val,
   input  logic              bus_rd,
   input  logic              bus_rmw,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe
);

   generate
      if (WIDTH < 2 || (1 << IDX_W) != WIDTH) begin : g_bad_width
         $error("gpio_port_sfr: WIDTH must be a power of two, at least 2");
      end
      if (PIN_ADDR == LATCH_ADDR) begin : g_bad_addr
         $error("gpio_port_sfr: pin and latch addresses must differ");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("gpio_port_sfr: SYNC_STAGES must be at least 1");
      end
   endgenerate

   addr_hit_t        hit;
   rd_src_e          rd_src;
   logic             port_hit;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_q;

   gpio_port_decode #(
      .ADDR_W          (ADDR_W),
      .PIN_ADDR        (PIN_ADDR),
      .LATCH_ADDR      (LATCH_ADDR),
      .RMW_READS_LATCH (RMW_READS_LATCH)
   ) u_decode (
      .addr   (bus_addr),
      .rd     (bus_rd),
      .rmw    (bus_rmw),
      .hit    (hit),
      .rd_src (rd_src)
   );

   assign port_hit = hit.pin_view | hit.latch_view;

   gpio_port_latch #(
      .WIDTH   (WIDTH),
      .RST_VAL (RELEASED)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr & port_hit),
      .wdata   (bus_wdata),
      .bit_en  (bus_bit_op & port_hit),
      .bit_idx (bus_bit_idx),
      .bit_val (bus_bit_val),
      .q       (latch_q)
   );

   gpio_port_sync #(
      .WIDTH   (WIDTH),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (RELEASED)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_q)
   );

   always_comb begin
      unique case (rd_src)
         SRC_PIN:   bus_rdata = pin_q;
         SRC_LATCH: bus_rdata = latch_q;
         default:   bus_rdata = '0;
      endcase
   end

   // open drain: a 0 in the latch pulls the pad low
   assign pad_oe = ~latch_q;

endmodule

// File: rtl/gpio_port_sfr_chk.sv
module gpio_port_sfr_chk #(
   parameter int WIDTH                 = 8,
   parameter int ADDR_W                = 8,
   parameter logic [ADDR_W-1:0] PIN_ADDR   = 8'h80,
   parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'hC0,
   localparam int IDX_W                = $clog2(WIDTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic              bus_bit_op,
   input logic [IDX_W-1:0]  bus_bit_idx,
   input logic              bus_bit_val,
   input logic              bus_rd,
   input logic              bus_rmw,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pad_in,
   input logic [WIDTH-1:0]  pad_oe
);

   logic       at_port;
   logic [1:0] edges_since_rst;
   logic [WIDTH-1:0] keep_mask;

   assign at_port   = (bus_addr == PIN_ADDR) || (bus_addr == LATCH_ADDR);
   assign keep_mask = ~(WIDTH'(1) << bus_bit_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    edges_since_rst <= 2'd0;
      else if (edges_since_rst != 2'd2) edges_since_rst <= edges_since_rst + 2'd1;
   end

   AST_RESET_RELEASED: assert property (@(posedge clk)
      !rst_n |=> pad_oe == '0); // R1

   AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && at_port) |=> pad_oe == ~$past(bus_wdata)); // R2

   AST_BIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_bit_op && !bus_wr && at_port) |=> pad_oe[$past(bus_bit_idx)] == !$past(bus_bit_val)); // R3

   AST_BIT_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_bit_op && !bus_wr && at_port) |=> ((pad_oe ^ $past(pad_oe)) & $past(keep_mask)) == '0); // R3

   AST_PIN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_since_rst == 2'd2 && bus_rd && !bus_rmw && bus_addr == PIN_ADDR)
         |-> bus_rdata == $past(pad_in, 2)); // R4

   AST_RMW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_rmw && bus_addr == PIN_ADDR) |-> bus_rdata == ~pad_oe); // R5

   AST_ALIAS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == LATCH_ADDR) |-> bus_rdata == ~pad_oe); // R6

   AST_FOREIGN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !at_port |=> $stable(pad_oe)); // R8

   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0); // R9

endmodule

bind gpio_port_sfr gpio_port_sfr_chk #(
   .WIDTH      (WIDTH),
   .ADDR_W     (ADDR_W),
   .PIN_ADDR   (PIN_ADDR),
   .LATCH_ADDR (LATCH_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .bus_bit_op  (bus_bit_op),
   .bus_bit_idx (bus_bit_idx),
   .bus_bit_val (bus_bit_val),
   .bus_rd      (bus_rd),
   .bus_rmw     (bus_rmw),
   .bus_rdata   (bus_rdata),
   .pad_in      (pad_in),
   .pad_oe      (pad_oe)
);

// File: tb/gpio_port_sfr_tb_top.sv
module gpio_port_sfr_tb_top;

   localparam logic [7:0] A_PIN   = 8'h80;
   localparam logic [7:0] A_LATCH = 8'hC0;
   localparam logic [7:0] A_OTHER = 8'h81;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_bit_op = 1'b0;
   logic [2:0] bus_bit_idx = '0;
   logic       bus_bit_val = 1'b0;
   logic       bus_rd = 1'b0;
   logic       bus_rmw = 1'b0;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = 8'hFF;
   logic [7:0] pad_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] exp_q [$];
   string      req_q [$];

   always #2 clk = ~clk;

   gpio_port_sfr dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_bit_op  (bus_bit_op),
      .bus_bit_idx (bus_bit_idx),
      .bus_bit_val (bus_bit_val),
      .bus_rd      (bus_rd),
      .bus_rmw     (bus_rmw),
      .bus_rdata   (bus_rdata),
      .pad_in      (pad_in),
      .pad_oe      (pad_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      bus_wr = 1'b0; bus_bit_op = 1'b0; bus_rd = 1'b0; bus_rmw = 1'b0;
      bus_addr = '0;
   endtask

   task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      tick(); idle();
   endtask

   task automatic bit_op(input logic [7:0] a, input logic [2:0] idx, input logic v);
      bus_addr = a; bus_bit_op = 1'b1; bus_bit_idx = idx; bus_bit_val = v;
      tick(); idle();
   endtask

   // driver: push expectation, then present the read for one cycle
   task automatic rd_port(input logic [7:0] a, input logic rmw,
                          input logic [7:0] exp, input string req);
      exp_q.push_back(exp);
      req_q.push_back(req);
      bus_addr = a; bus_rd = 1'b1; bus_rmw = rmw;
      tick(); idle();
   endtask

   // monitor: compare read data mid-cycle
   always @(negedge clk) begin
      if (rst_n && bus_rd) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard: act=%02h exp=none", bus_rdata);
         end else begin
            check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: act=timeout exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      check("R1 oe after reset", pad_oe, 8'h00);
      rd_port(A_LATCH, 1'b0, 8'hFF, "R1 latch after reset");

      wr_byte(A_PIN, 8'hA5);
      check("R2 write pin addr", pad_oe, 8'h5A);
      wr_byte(A_LATCH, 8'h3C);
      check("R2 write latch addr", pad_oe, 8'hC3);

      rd_port(A_LATCH, 1'b0, 8'h3C, "R6 alias plain");
      rd_port(A_LATCH, 1'b1, 8'h3C, "R6 alias rmw");

      pad_in = 8'h96;
      tick();
      rd_port(A_PIN, 1'b0, 8'hFF, "R4 one edge lag");
      rd_port(A_PIN, 1'b0, 8'h96, "R4 after two edges");
      rd_port(A_PIN, 1'b1, 8'h3C, "R5 rmw read latch");

      bit_op(A_LATCH, 3'd2, 1'b0);
      check("R3 clear bit2", pad_oe, 8'hC7);
      bit_op(A_PIN, 3'd7, 1'b1);
      check("R3 set bit7", pad_oe, 8'h47);

      bus_addr = A_PIN; bus_wr = 1'b1; bus_wdata = 8'h5A;
      bus_bit_op = 1'b1; bus_bit_idx = 3'd0; bus_bit_val = 1'b1;
      tick(); idle();
      check("R10 byte write wins", pad_oe, 8'hA5);

      wr_byte(A_OTHER, 8'h00);
      check("R8 foreign write", pad_oe, 8'hA5);
      bit_op(A_OTHER, 3'd1, 1'b0);
      check("R8 foreign bit op", pad_oe, 8'hA5);
      rd_port(A_OTHER, 1'b0, 8'h00, "R8 foreign read");

      bus_addr = A_LATCH; bus_rd = 1'b0;
      #1;
      check("R9 no read strobe", bus_rdata, 8'h00);
      idle();

      // slow pad: latch set but pad held low
      wr_byte(A_PIN, 8'h00);
      pad_in = 8'h00;
      tick(); tick();
      bit_op(A_PIN, 3'd0, 1'b1);
      rd_port(A_PIN, 1'b0, 8'h00, "R7 pad still low");
      bit_op(A_PIN, 3'd1, 1'b1);
      check("R7 bit0 kept", pad_oe, 8'hFC);
      rd_port(A_PIN, 1'b1, 8'h03, "R7 latch view");

      // external device pulls a released line
      wr_byte(A_PIN, 8'hFF);
      pad_in = 8'hEF;
      tick(); tick();
      check("R11 released oe", pad_oe, 8'h00);
      rd_port(A_PIN, 1'b0, 8'hEF, "R11 sense line");
      rd_port(A_LATCH, 1'b0, 8'hFF, "R11 latch unchanged");

      tick();
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard: act=%0d exp=0 pending", exp_q.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule